// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block records when external events happen. It has four capture channels. Each channel watches one asynchronous input pin. When the edge chosen for that channel appears on its pin, the channel stores the free-running timer count in its own capture register and sets its sticky capture flag. The count comes from outside the block.

Each pin passes through a two-flop synchroniser before edge detection. Each channel takes a 2-bit edge code from the register interface, which enables capture on rising edges, falling edges, both edges, or neither. Software clears flags by writing a mask; a one in the mask clears the flag in that bit position. Each flag can be routed to a single interrupt request line through a per-channel enable bit.

Top module: `edge_capture_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, every capture register, every flag and `irq` are cleared to zero.
- R2: Edge code 1 on a channel captures on a low-to-high change of its pin and ignores a high-to-low change.
- R3: Edge code 2 on a channel captures on a high-to-low change of its pin and ignores a low-to-high change.
- R4: Edge code 3 on a channel captures on either change of its pin.
- R5: Edge code 0 disables a channel: its capture register and its flag keep their values whatever its pin does.
- R6: A capture loads the `count_in` value present at the third rising clock edge after the pin change. The flag rises at that same edge, and neither output changes at the second edge.
- R7: A capture on one channel leaves the capture registers and flags of the other channels unchanged.
- R8: A cycle with `clr_wr` high clears exactly the flags whose bit is set in `clr_mask` (bit i for channel i), taking effect at the next clock edge.
- R9: When a capture and a clear of the same flag fall on the same clock edge, the flag ends up set.
- R10: `irq` is high exactly when at least one channel has both its flag and its `irq_en` bit set. It follows those bits in the same cycle.
- R11: A new capture overwrites the capture register even when that channel's flag is still set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_in | input | CNT_W (32) | Timer count to be captured |
| cap_pin | input | NCH (4) | Asynchronous capture pins, bit i for channel i |
| edge_sel | input | 2*NCH (8) | Edge codes, bits [2i+1:2i] for channel i: 0 off, 1 rise, 2 fall, 3 both |
| irq_en | input | NCH (4) | Per-channel interrupt enables |
| clr_wr | input | 1 | Strobe for a flag-clear write |
| clr_mask | input | NCH (4) | Flags to clear when `clr_wr` is high |
| cap_val | output | NCH*CNT_W (128) | Capture registers, bits [CNT_W*i +: CNT_W] for channel i |
| cap_flag | output | NCH (4) | Sticky capture flags |
| irq | output | 1 | Interrupt request |

## Verification
Each pin sees rising and falling transitions under all four edge codes. This separates correct edge qualification from captures on the wrong edge or on every change. The timer count steps by one every cycle, so a capture value that is one stage early or late is wrong by one and shows up as a mismatch. The flag is also sampled one cycle before the expected edge. Random sequences mix channels, codes, enables and clear masks, which exposes crosstalk between channels and clearing of the wrong bit. A directed case places a clear on the same edge as a capture to check that the set wins.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    function automatic edge_ev_t detect_edges(input logic now_lvl, input logic old_lvl);
        edge_ev_t ev;
        ev.rise = now_lvl & ~old_lvl;
        ev.fall = ~now_lvl & old_lvl;
        return ev;
    endfunction

    function automatic logic edge_qualifies(input edge_mode_e mode, input edge_ev_t ev);
        logic q;
        unique case (mode)
            EDGE_RISE: q = ev.rise;
            EDGE_FALL: q = ev.fall;
            EDGE_BOTH: q = ev.rise | ev.fall;
            default:   q = 1'b0;
        endcase
        return q;
    endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic lvl_now,
    output logic lvl_old
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= pin_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], pin_async};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) lvl_old <= 1'b0;
        else     lvl_old <= chain[STAGES-1];
    end

    assign lvl_now = chain[STAGES-1];
endmodule

// File: rtl/cap_channel.sv
module cap_channel
    import cap_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_async,
    input  logic [1:0]       mode_code,
    input  logic [CNT_W-1:0] count_in,
    output logic             hit,
    output logic [CNT_W-1:0] held
);
    logic       lvl_now;
    logic       lvl_old;
    edge_ev_t   ev;
    edge_mode_e mode;

    cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_async(pin_async),
        .lvl_now  (lvl_now),
        .lvl_old  (lvl_old)
    );

    always_comb begin
        mode = edge_mode_e'(mode_code);
        ev   = detect_edges(lvl_now, lvl_old);
        hit  = edge_qualifies(mode, ev);
    end

    always_ff @(posedge clk) begin
        if (rst)      held <= '0;
        else if (hit) held <= count_in;
    end
endmodule

// File: rtl/cap_status.sv
module cap_status #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] hit,
    input  logic           clr_wr,
    input  logic [NCH-1:0] clr_mask,
    input  logic [NCH-1:0] irq_en,
    output logic [NCH-1:0] flags,
    output logic           irq
);
    logic [NCH-1:0] clr_eff;

    assign clr_eff = clr_wr ? clr_mask : '0;

    genvar i;
    generate
        for (i = 0; i < NCH; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)             flags[i] <= 1'b0;
                else if (hit[i])     flags[i] <= 1'b1;
                else if (clr_eff[i]) flags[i] <= 1'b0;
            end
        end
    endgenerate

    assign irq = |(flags & irq_en);
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import cap_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CNT_W-1:0]     count_in,
    input  logic [NCH-1:0]       cap_pin,
    input  logic [2*NCH-1:0]     edge_sel,
    input  logic [NCH-1:0]       irq_en,
    input  logic                 clr_wr,
    input  logic [NCH-1:0]       clr_mask,
    output logic [NCH*CNT_W-1:0] cap_val,
    output logic [NCH-1:0]       cap_flag,
    output logic                 irq
);
    logic [NCH-1:0] hit_vec;

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            cap_channel #(
                .CNT_W      (CNT_W),
                .SYNC_STAGES(SYNC_STAGES)
            ) u_ch (
                .clk      (clk),
                .rst      (rst),
                .pin_async(cap_pin[c]),
                .mode_code(edge_sel[2*c +: 2]),
                .count_in (count_in),
                .hit      (hit_vec[c]),
                .held     (cap_val[CNT_W*c +: CNT_W])
            );
        end
    endgenerate

    cap_status #(.NCH(NCH)) u_status (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit_vec),
        .clr_wr  (clr_wr),
        .clr_mask(clr_mask),
        .irq_en  (irq_en),
        .flags   (cap_flag),
        .irq     (irq)
    );
endmodule

// File: rtl/edge_capture_unit_chk.sv
module edge_capture_unit_chk #(
    parameter int NCH   = 4,
    parameter int CNT_W = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic [CNT_W-1:0]     count_in,
    input logic [2*NCH-1:0]     edge_sel,
    input logic [NCH-1:0]       irq_en,
    input logic                 clr_wr,
    input logic [NCH-1:0]       clr_mask,
    input logic [NCH*CNT_W-1:0] cap_val,
    input logic [NCH-1:0]       cap_flag,
    input logic                 irq,
    input logic [NCH-1:0]       hit_vec
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (cap_flag == '0 && cap_val == '0 && !irq));

    a_r10_irq_gated: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> !irq);

    genvar i;
    generate
        for (i = 0; i < NCH; i++) begin : g_chk
            a_r8_clear_takes: assert property (@(posedge clk) disable iff (rst)
                (clr_wr && clr_mask[i] && !hit_vec[i]) |=> !cap_flag[i]);

            a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
                hit_vec[i] |=> cap_flag[i]);

            a_r11_loads_count: assert property (@(posedge clk) disable iff (rst)
                hit_vec[i] |=> (cap_val[CNT_W*i +: CNT_W] == $past(count_in)));

            a_r5_off_holds: assert property (@(posedge clk) disable iff (rst)
                ($past(edge_sel[2*i +: 2]) == 2'd0 && !$past(rst))
                |-> (cap_val[CNT_W*i +: CNT_W] == $past(cap_val[CNT_W*i +: CNT_W])));
        end
    endgenerate
endmodule

bind edge_capture_unit edge_capture_unit_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .count_in(count_in),
    .edge_sel(edge_sel),
    .irq_en  (irq_en),
    .clr_wr  (clr_wr),
    .clr_mask(clr_mask),
    .cap_val (cap_val),
    .cap_flag(cap_flag),
    .irq     (irq),
    .hit_vec (hit_vec)
);

// File: tb/sim_edge_capture_unit.sv
`timescale 1ns/1ps
module sim_edge_capture_unit;
    localparam int NCH    = 4;
    localparam int CNT_W  = 32;
    localparam int CLK_PERIOD = 10;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [CNT_W-1:0]     count_in = '0;
    logic [NCH-1:0]       cap_pin = '0;
    logic [2*NCH-1:0]     edge_sel = '0;
    logic [NCH-1:0]       irq_en = '0;
    logic                 clr_wr = 1'b0;
    logic [NCH-1:0]       clr_mask = '0;
    logic [NCH*CNT_W-1:0] cap_val;
    logic [NCH-1:0]       cap_flag;
    logic                 irq;

    int checks = 0;
    int fails  = 0;
    logic [CNT_W-1:0] exp_val [NCH];
    logic [NCH-1:0]   exp_flag = '0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) count_in <= count_in + 1;

    edge_capture_unit #(.NCH(NCH), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .count_in(count_in), .cap_pin(cap_pin),
        .edge_sel(edge_sel), .irq_en(irq_en), .clr_wr(clr_wr), .clr_mask(clr_mask),
        .cap_val(cap_val), .cap_flag(cap_flag), .irq(irq)
    );

    function automatic logic want_capture(input logic [1:0] code, input logic old_l, input logic new_l);
        logic r, f;
        r = !old_l && new_l;
        f = old_l && !new_l;
        case (code)
            2'd1: return r;
            2'd2: return f;
            2'd3: return r | f;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic exp_irq(input logic [NCH-1:0] fl, input logic [NCH-1:0] en);
        return |(fl & en);
    endfunction

    task automatic check(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < NCH; k++) begin
            check(req, cap_val[CNT_W*k +: CNT_W], exp_val[k]);
        end
        check(req, {28'd0, cap_flag}, {28'd0, exp_flag});
        check({req, " R10 irq"}, {31'd0, irq}, {31'd0, exp_irq(exp_flag, irq_en)});
    endtask

    task automatic pin_event(input int ch, input logic lvl, input string req);
        logic old_l;
        logic [CNT_W-1:0] c0;
        logic cap;
        @(negedge clk); #1;
        old_l = cap_pin[ch];
        cap_pin[ch] = lvl;
        c0 = count_in;
        cap = want_capture(edge_sel[2*ch +: 2], old_l, lvl);
        @(negedge clk);
        @(negedge clk);
        check_all({req, " R6 before third edge"});
        @(negedge clk);
        if (cap) begin
            exp_val[ch] = c0 + 2;
            exp_flag[ch] = 1'b1;
        end
        check_all({req, " R7 after capture"});
    endtask

    task automatic do_clear(input logic [NCH-1:0] m);
        @(negedge clk); #1;
        clr_wr = 1'b1; clr_mask = m;
        @(negedge clk); #1;
        clr_wr = 1'b0; clr_mask = '0;
        exp_flag = exp_flag & ~m;
        check_all("R8 clear mask");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < NCH; k++) exp_val[k] = '0;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset state");

        irq_en = 4'hF;
        edge_sel = {2'd0, 2'd3, 2'd2, 2'd1};
        pin_event(0, 1'b1, "R2 rise code1");
        pin_event(0, 1'b0, "R2 fall ignored code1");
        pin_event(1, 1'b1, "R3 rise ignored code2");
        pin_event(1, 1'b0, "R3 fall code2");
        pin_event(2, 1'b1, "R4 rise code3");
        pin_event(2, 1'b0, "R4 fall code3");
        pin_event(3, 1'b1, "R5 disabled rise");
        pin_event(3, 1'b0, "R5 disabled fall");
        pin_event(0, 1'b1, "R11 overwrite with flag set");
        do_clear(4'b0101);
        irq_en = 4'b0001;
        @(negedge clk);
        check_all("R10 enable mask");
        do_clear(4'b0010);

        // R9: clear strobe aligned with the capture edge
        edge_sel[2*3 +: 2] = 2'd1;
        @(negedge clk); #1;
        cap_pin[3] = 1'b1;
        exp_val[3] = count_in + 2;
        @(negedge clk);
        @(negedge clk); #1;
        clr_wr = 1'b1; clr_mask = 4'b1000;
        @(negedge clk); #1;
        clr_wr = 1'b0; clr_mask = '0;
        exp_flag[3] = 1'b1;
        check_all("R9 set wins over clear");

        for (int it = 0; it < 60; it++) begin
            int ch;
            ch = int'($urandom % NCH);
            edge_sel[2*ch +: 2] = 2'($urandom);
            irq_en = 4'($urandom);
            if (($urandom % 4) == 0) do_clear(4'($urandom));
            pin_event(ch, ~cap_pin[ch], "R7 random");
        end

        #1 rst = 1'b1;
        @(negedge clk); #1 rst = 1'b0;
        for (int k = 0; k < NCH; k++) exp_val[k] = '0;
        exp_flag = '0;
        check_all("R1 reset mid-run");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule